// File: doc/BRIEF.md
# Channel Address Compaction Unit

This block turns a system physical address into the address seen by one memory channel. It takes the settings of the address-decode rule that already matched. Those settings are a signed offset counted in 64 KiB units, three flags that squeeze out address bits 8, 7 and 6, and a flag that divides the line index by three for three-way interleave. The unit holds one such settings set for each channel. It picks one set from the requested channel, except in paired (lockstep or mirrored) operation, where it always uses channel 0.

The unit is a three-stage pipeline with no back-pressure. Stage one selects the settings and adds the offset. Stage two squeezes out the interleave bits in a fixed order. Stage three runs an exact divide-by-three on the line index. One address can enter on every cycle.

Top module: `chan_addr_squeeze`

## Requirements
- R1: Every cycle with `in_valid` high gives exactly one cycle with `out_valid` high, three rising edges later. Back-to-back inputs are accepted without stalls, and `out_valid` stays low in cycles that no input maps to.
- R2: While `rst_n` is low, `out_valid` and `out_addr` are 0.
- R3: With no flags set, the result has three parts. Bits [36:16] are (address bits [39:16] + sign-extended offset) modulo 2^21. Bits [15:6] equal address bits [15:6]. Bits [5:0] are 0. `in_line_addr` carries address bits [39:6].
- R4: When drop-8 is set, bits [7:0] of the intermediate value stay in place and every bit above bit 8 moves down by one position.
- R5: When drop-7 is set, bits [6:0] stay in place and every bit above bit 7 moves down by one.
- R6: When drop-6 is set, bits [5:0] stay in place and every bit above bit 6 moves down by one.
- R7: When several drop flags are set, the drops are applied in the order bit 8, then bit 7, then bit 6. Each drop works on the result of the one before.
- R8: After the drops, only bits [36:0] are kept. Higher bits of the sum are discarded.
- R9: When divide-by-3 is set, bits [36:6] are replaced by their exact integer quotient by 3 and bits [5:0] are kept. This holds for every 31-bit dividend, so bit 36 of such a result is always 0.
- R10: Channel i (0..2) uses the offset at `cfg_offset[16*i +: 16]` and bit i of each flag vector. A channel number of 3 selects channel 0.
- R11: When `in_pair_mode` is high, the channel-0 settings are used whatever `in_chan` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address present this cycle |
| in_line_addr | input | 34 | System address bits [39:6] |
| in_chan | input | 2 | Target channel number |
| in_pair_mode | input | 1 | Lockstep/mirrored operation: use channel 0 settings |
| cfg_offset | input | 48 | Per-channel signed offset in 64 KiB units, 16 bits per channel |
| cfg_drop8 | input | 3 | Per-channel flag: squeeze out bit 8 |
| cfg_drop7 | input | 3 | Per-channel flag: squeeze out bit 7 |
| cfg_drop6 | input | 3 | Per-channel flag: squeeze out bit 6 |
| cfg_div3 | input | 3 | Per-channel flag: divide line index by 3 |
| out_valid | output | 1 | Channel address present |
| out_addr | output | 37 | Channel address |

## Verification
Every result is due three rising edges after the edge that samples its input, whatever the flags. The bench drives inputs on falling edges. When it issues an input, it stamps the expected item with the cycle number in which the output must show. The monitor samples on falling edges and fails any result that arrives in another cycle, and it flags a due item that never appears. Expected values come from a 64-bit software model of the offset, drop, mask and divide steps. The model is exercised at divide boundaries (0 to 5, the largest 31-bit dividends, and long random runs), with wrapping offsets, and with every mix of flags and channel selection.

// File: rtl/chan_addr_squeeze.sv
module chan_addr_squeeze #(
  parameter int CH_W  = 37,
  parameter int NCH   = 3,
  parameter int OFF_W = 16,
  parameter int LINE  = 6,
  parameter int GRAN  = 16,
  localparam int ADDR_W = CH_W + 3,
  localparam int CS_W   = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:LINE]   in_line_addr,
  input  logic [CS_W-1:0]        in_chan,
  input  logic                   in_pair_mode,
  input  logic [NCH*OFF_W-1:0]   cfg_offset,
  input  logic [NCH-1:0]         cfg_drop8,
  input  logic [NCH-1:0]         cfg_drop7,
  input  logic [NCH-1:0]         cfg_drop6,
  input  logic [NCH-1:0]         cfg_div3,
  output logic                   out_valid,
  output logic [CH_W-1:0]        out_addr
);
  localparam int UP_W = ADDR_W - GRAN;
  localparam int W1   = ADDR_W - 1;
  localparam int W2   = ADDR_W - 2;
  localparam int Q_W  = CH_W - LINE;

  logic [CS_W-1:0]   sel;
  logic [OFF_W-1:0]  off;
  logic [UP_W-1:0]   up_sum;

  assign sel    = (in_pair_mode || int'(in_chan) >= NCH) ? '0 : in_chan;
  assign off    = cfg_offset[sel*OFF_W +: OFF_W];
  assign up_sum = in_line_addr[ADDR_W-1:GRAN] + {{(UP_W-OFF_W){off[OFF_W-1]}}, off};

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [2:0]        s1_drop;
  logic              s1_div3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_drop  <= '0;
      s1_div3  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_addr  <= {up_sum, in_line_addr[GRAN-1:LINE], {LINE{1'b0}}};
      s1_drop  <= {cfg_drop8[sel], cfg_drop7[sel], cfg_drop6[sel]};
      s1_div3  <= cfg_div3[sel];
    end
  end

  logic [W1-1:0]   a8;
  logic [W2-1:0]   a7;
  logic [CH_W-1:0] a6;

  assign a8 = s1_drop[2] ? {s1_addr[ADDR_W-1:LINE+3], s1_addr[LINE+1:0]} : s1_addr[ADDR_W-2:0];
  assign a7 = s1_drop[1] ? {a8[W1-1:LINE+2], a8[LINE:0]} : a8[W1-2:0];
  assign a6 = s1_drop[0] ? {a7[W2-1:LINE+1], a7[LINE-1:0]} : a7[W2-2:0];

  logic            s2_valid;
  logic [CH_W-1:0] s2_addr;
  logic            s2_div3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_addr  <= '0;
      s2_div3  <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      s2_addr  <= a6;
      s2_div3  <= s1_div3;
    end
  end

  logic [Q_W-1:0] quo;
  logic [1:0]     rem;
  logic [2:0]     step;

  always_comb begin
    quo  = '0;
    rem  = '0;
    step = '0;
    for (int i = Q_W - 1; i >= 0; i--) begin
      step = {rem, s2_addr[LINE+i]};
      if (step >= 3'd3) begin
        quo[i] = 1'b1;
        rem    = 2'(step - 3'd3);
      end else begin
        rem    = step[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= s2_valid;
      out_addr  <= s2_div3 ? {quo, s2_addr[LINE-1:0]} : s2_addr;
    end
  end
endmodule

// File: rtl/chan_addr_squeeze_sva.sv
module chan_addr_squeeze_sva #(
  parameter int NCH  = 3,
  parameter int LINE = 6,
  parameter int GRAN = 16,
  localparam int CS_W = $clog2(NCH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [GRAN-1:LINE]   mid_bits,
  input logic [CS_W-1:0]      in_chan,
  input logic                 in_pair_mode,
  input logic [NCH-1:0]       cfg_drop8,
  input logic [NCH-1:0]       cfg_drop7,
  input logic [NCH-1:0]       cfg_drop6,
  input logic [NCH-1:0]       cfg_div3,
  input logic                 out_valid,
  input logic [GRAN-1:0]      out_lo,
  input logic                 out_msb
);
  logic [1:0]      since_rst;
  logic [CS_W-1:0] pick;
  logic            plain_in;
  logic            div_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign pick     = (in_pair_mode || int'(in_chan) >= NCH) ? '0 : in_chan;
  assign plain_in = in_valid && !cfg_drop8[pick] && !cfg_drop7[pick] && !cfg_drop6[pick] && !cfg_div3[pick];
  assign div_in   = in_valid && cfg_div3[pick];

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> !out_valid);

  p_line_bits_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lo[LINE-1:0] == '0));

  p_mid_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(plain_in, 3)) |-> (out_lo[GRAN-1:LINE] == $past(mid_bits, 3)));

  p_quotient_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(div_in, 3)) |-> !out_msb);
endmodule

bind chan_addr_squeeze chan_addr_squeeze_sva #(
  .NCH(NCH), .LINE(LINE), .GRAN(GRAN)
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .mid_bits(in_line_addr[GRAN-1:LINE]), .in_chan(in_chan),
  .in_pair_mode(in_pair_mode), .cfg_drop8(cfg_drop8), .cfg_drop7(cfg_drop7),
  .cfg_drop6(cfg_drop6), .cfg_div3(cfg_div3), .out_valid(out_valid),
  .out_lo(out_addr[GRAN-1:0]), .out_msb(out_addr[CH_W-1])
);

// File: tb/chan_addr_squeeze_tb.sv
module chan_addr_squeeze_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:6] in_line_addr = '0;
  logic [1:0]  in_chan = '0;
  logic        in_pair_mode = 1'b0;
  logic [47:0] cfg_offset = '0;
  logic [2:0]  cfg_drop8 = '0, cfg_drop7 = '0, cfg_drop6 = '0, cfg_div3 = '0;
  logic        out_valid;
  logic [36:0] out_addr;

  chan_addr_squeeze u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_addr(in_line_addr),
    .in_chan(in_chan), .in_pair_mode(in_pair_mode), .cfg_offset(cfg_offset),
    .cfg_drop8(cfg_drop8), .cfg_drop7(cfg_drop7), .cfg_drop6(cfg_drop6),
    .cfg_div3(cfg_div3), .out_valid(out_valid), .out_addr(out_addr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [36:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [36:0] model(input logic [39:0] a, input logic [15:0] off,
                                        input bit d8, input bit d7, input bit d6, input bit dv);
    logic [63:0] c;
    logic [63:0] o;
    o = {{48{off[15]}}, off};
    c = (((64'(a) >> 16) + o) << 16) | (64'(a) & 64'hFFC0);
    if (d8) c = ((c >> 1) & ~64'hFF) | (c & 64'hFF);
    if (d7) c = ((c >> 1) & ~64'h7F) | (c & 64'h7F);
    if (d6) c = ((c >> 1) & ~64'h3F) | (c & 64'h3F);
    c = c & 64'h1F_FFFF_FFFF;
    if (dv) c = (((c >> 6) / 3) << 6) | (c & 64'h3F);
    return c[36:0];
  endfunction

  task automatic set_cfg(input int ch, input logic [15:0] off, input bit d8, input bit d7,
                         input bit d6, input bit dv);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_offset[ch*16 +: 16] = off;
    cfg_drop8[ch] = d8;
    cfg_drop7[ch] = d7;
    cfg_drop6[ch] = d6;
    cfg_div3[ch]  = dv;
  endtask

  task automatic send(input logic [39:0] a, input int ch, input bit pair, input string tag);
    int s;
    s = (pair || ch >= 3) ? 0 : ch;
    @(negedge clk);
    in_valid = 1'b1;
    in_line_addr = a[39:6];
    in_chan = 2'(ch);
    in_pair_mode = pair;
    exp_q.push_back(model(a, cfg_offset[s*16 +: 16], cfg_drop8[s], cfg_drop7[s], cfg_drop6[s], cfg_div3[s]));
    due_q.push_back(cyc + 3);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected out_valid", 64'(out_addr), 64'(0));
        end else begin
          logic [36:0] e;
          int d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          chk(d == cyc, "R1 latency", 64'(cyc), 64'(d));
          chk(out_addr == e, t, 64'(out_addr), 64'(e));
        end
      end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
        chk(1'b0, {"R1 missing result for ", tag_q[0]}, 64'(0), 64'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    // R2: reset state
    repeat (2) begin
      @(negedge clk);
      in_valid = 1'b1;
      chk(out_valid == 1'b0, "R2 out_valid in reset", 64'(out_valid), 64'(0));
      chk(out_addr == '0, "R2 out_addr in reset", 64'(out_addr), 64'(0));
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R3: offset and pass-through, including negative wrap
    set_cfg(0, 16'h0000, 0, 0, 0, 0);
    send(40'h12_3456_789A, 0, 0, "R3 zero offset");
    send(40'h00_0000_FFFF, 0, 0, "R3 low bits");
    set_cfg(0, 16'h0123, 0, 0, 0, 0);
    send(40'h0A_BCDE_F040, 0, 0, "R3 positive offset");
    set_cfg(0, 16'hFFFF, 0, 0, 0, 0);
    send(40'h00_0000_1FC0, 0, 0, "R3 negative offset wrap");
    send(40'h01_0002_0000, 0, 0, "R3 negative offset");
    idle(4);

    // R8: bits above 36 dropped
    set_cfg(0, 16'h0000, 0, 0, 0, 0);
    send(40'hE5_5555_5540, 0, 0, "R8 top bits dropped");
    set_cfg(0, 16'h7FFF, 0, 0, 0, 0);
    send(40'h1F_FFFF_0000, 0, 0, "R8 carry past bit 36");

    // R4 R5 R6 single drops
    set_cfg(0, 16'h0000, 1, 0, 0, 0);
    send(40'hFF_FFFF_FEC0, 0, 0, "R4 drop bit 8");
    send(40'h5A_5A5A_5B40, 0, 0, "R4 drop bit 8 pattern");
    set_cfg(0, 16'h0000, 0, 1, 0, 0);
    send(40'hFF_FFFF_FF40, 0, 0, "R5 drop bit 7");
    send(40'h5A_5A5A_5AC0, 0, 0, "R5 drop bit 7 pattern");
    set_cfg(0, 16'h0000, 0, 0, 1, 0);
    send(40'hFF_FFFF_FF80, 0, 0, "R6 drop bit 6");
    send(40'h5A_5A5A_5A40, 0, 0, "R6 drop bit 6 pattern");

    // R7: combinations in fixed order
    for (int m = 3; m < 8; m++) begin
      if (m == 4) continue;
      set_cfg(0, 16'h0031, m[2], m[1], m[0], 0);
      send(40'hC3_9E1D_55C0, 0, 0, "R7 drop order");
      send(40'h3C_61E2_AA40, 0, 0, "R7 drop order");
    end
    idle(4);

    // R9: exact divide by 3 at boundaries
    set_cfg(0, 16'h0000, 0, 0, 0, 1);
    for (int x = 0; x < 6; x++) send({3'b000, 31'(x), 6'b0}, 0, 0, "R9 small dividend");
    send({3'b000, 31'h7FFF_FFFF, 6'b0}, 0, 0, "R9 max dividend");
    send({3'b000, 31'h7FFF_FFFE, 6'b0}, 0, 0, "R9 max-1 dividend");
    send({3'b000, 31'h7FFF_FFFD, 6'b0}, 0, 0, "R9 max-2 dividend");
    send({3'b000, 31'h5555_5555, 6'b0}, 0, 0, "R9 pattern dividend");
    send({3'b000, 31'h2AAA_AAAA, 6'b0}, 0, 0, "R9 pattern dividend");
    for (int k = 0; k < 400; k++) send({3'b000, 31'($urandom), 6'b0}, 0, 0, "R9 random dividend");
    set_cfg(0, 16'hFF00, 1, 1, 1, 1);
    send(40'hFF_FFFF_FFC0, 0, 0, "R9 divide after drops");
    idle(4);

    // R10: per-channel settings and out-of-range channel
    set_cfg(0, 16'h0010, 0, 0, 0, 0);
    set_cfg(1, 16'hFFF0, 1, 0, 0, 0);
    set_cfg(2, 16'h0200, 0, 1, 1, 1);
    send(40'h33_4455_66C0, 0, 0, "R10 channel 0");
    send(40'h33_4455_66C0, 1, 0, "R10 channel 1");
    send(40'h33_4455_66C0, 2, 0, "R10 channel 2");
    send(40'h33_4455_66C0, 3, 0, "R10 channel 3 maps to 0");

    // R11: pair mode ignores in_chan
    send(40'h33_4455_66C0, 1, 1, "R11 pair mode chan 1");
    send(40'h33_4455_66C0, 2, 1, "R11 pair mode chan 2");
    idle(1);

    // R1: bursts with gaps, random settings and addresses
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0) begin
        for (int c = 0; c < 3; c++) begin
          logic [3:0] f;
          f = 4'($urandom);
          set_cfg(c, 16'($urandom), f[3], f[2], f[1], f[0]);
        end
      end
      send({8'($urandom), 32'($urandom)}, int'($urandom % 4), bit'($urandom % 2), "R7 random mix");
      if ($urandom % 4 == 0) idle(int'($urandom % 3) + 1);
    end
    idle(1);

    while (exp_q.size() > 0) @(negedge clk);
    idle(4);
    finish_run();
  end
endmodule